// File: doc/BRIEF.md
# Tile Accumulator with Decay and Range Latch

This block is the compute engine for one tile of a resonance fabric during its read phase. On a start strobe it samples eight raw input lanes, clamps each lane to a 4-bit level and records which lanes saturated. It then multiplies the lane vector by an 8x8 matrix of signed weights. Each weight is a 3-bit magnitude with a polarity bit. The matrix is processed one row per clock. Each row yields a rounded, clamped 4-bit output, and the signed row sums together form an update to a 16-bit signed accumulator.

The updated accumulator is pulled toward zero by a programmable decay amount and never crosses zero. It is then saturated to the signed 16-bit range. The tile latches when three things hold: the configuration is marked as applied, the new accumulator lies inside a programmed window, and the change was caused by signal or by decay. A latched tile drives its clamped input lanes unchanged. An unlatched tile drives its row outputs. A tile that arrives already latched skips the matrix and only has its accumulator decayed. An inactive tile is cleared.

The runtime state (accumulator and latch bit) is held by the caller. It is presented on `acc_in`/`locked_in` at start and returned on `acc_out`/`locked_out` together with a one-cycle `done`.

Top module: `tile_fuse_engine`

## Requirements
- R1: Each 8-bit raw lane is clamped to 0..15 for computation and drive. `lane_clip[i]` is 1 exactly when raw lane i exceeds 15 (active tiles only). Lane i occupies bits `[8i+7:8i]` of `lane_raw`.
- R2: For an active unlatched tile, row r sums `level[i]*mag[r][i]` over the lanes. Each term is added when `w_pos[8r+i]` is 1 and subtracted when it is 0. `mag[r][i]` is at `w_mag[3(8r+i)+:3]`. The row output is 0 for a sum <= 0, otherwise min(15, (sum+7)/8). A tile that does not latch drives row output r on `drive[4r+:4]`.
- R3: For an active unlatched tile, the new accumulator is `acc_in` plus the sum of all eight row sums. When the decay is nonzero, this value is moved toward zero by the decay without passing zero. It is then saturated to -32768..32767.
- R4: When `thr_lo >= thr_hi` the tile never latches.
- R5: An unlatched active tile latches when `bake_ok` is 1, `thr_lo <= acc_out <= thr_hi`, and either the row-sum total is nonzero or the decay is nonzero and the pre-decay value was outside the window. A tile that latches drives its clamped lanes.
- R6: An active tile with `locked_in`=1 keeps `locked_out`=1, raises no `fire`, and drives its clamped lanes. Its `acc_out` is `acc_in` decayed toward zero and saturated, with no weight contribution.
- R7: An inactive tile returns `acc_out`=0, `locked_out`=0, `drive`=0 and `lane_clip`=0.
- R8: `fire` is high, together with `done`, exactly when an unlatched tile latches.
- R9: `done` is a one-cycle pulse. It appears in the 1st clock after start is sampled for an inactive or already latched tile, and in the 10th clock for an active unlatched tile.
- R10: A start strobe that arrives while a computation is in progress is ignored.
- R11: After reset, `done`, `fire`, `locked_out`, `acc_out`, `drive` and `lane_clip` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one evaluation when idle |
| active | input | 1 | Tile lies on a live activation chain |
| locked_in | input | 1 | Latch state before this tick |
| bake_ok | input | 1 | Configuration has been applied |
| lane_raw | input | 64 | Eight raw lanes, 8 bits each |
| w_mag | input | 192 | 64 weight magnitudes, 3 bits each, row-major |
| w_pos | input | 64 | Weight polarity, 1 = positive |
| thr_lo | input | 16 | Signed lower window bound |
| thr_hi | input | 16 | Signed upper window bound |
| decay | input | 16 | Unsigned decay amount per tick |
| acc_in | input | 16 | Signed accumulator before this tick |
| acc_out | output | 16 | Signed accumulator after this tick |
| locked_out | output | 1 | Latch state after this tick |
| fire | output | 1 | Unlatched-to-latched transition pulse |
| done | output | 1 | Result valid pulse |
| drive | output | 32 | Eight 4-bit drive levels |
| lane_clip | output | 8 | Per-lane input saturation flags |

## Verification
The hardest outcome to reach from the ports is a latch caused by decay alone. It needs a zero matrix contribution, a pre-decay accumulator outside the window, and a post-decay value inside it. Random stimulus almost never lines these up, so directed cases zero every weight magnitude and place `acc_in` and the decay around the window edge, including a case that sits inside the window without any trigger. A second rare situation is a start strobe during the row sweep. The bench injects one mid-computation with different inputs and confirms that the first result is returned unchanged.

// File: rtl/tfe_pkg.sv
package tfe_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ROWS = 2'd1,
      ST_FIN  = 2'd2
   } tfe_state_e;
endpackage

// File: rtl/tfe_lane_clamp.sv
module tfe_lane_clamp #(
   parameter int RAW_W = 8,
   parameter int LVL_W = 4
) (
   input  logic [RAW_W-1:0] raw,
   output logic [LVL_W-1:0] lvl,
   output logic             clip
);
   localparam int unsigned LMAX = (1 << LVL_W) - 1;

   assign clip = raw > RAW_W'(LMAX);
   assign lvl  = clip ? LVL_W'(LMAX) : raw[LVL_W-1:0];
endmodule

// File: rtl/tfe_row_mac.sv
module tfe_row_mac #(
   parameter int LANES     = 8,
   parameter int LVL_W     = 4,
   parameter int MAG_W     = 3,
   parameter int ROW_W     = 11,
   parameter int ROW_SHIFT = 3
) (
   input  logic [LANES*LVL_W-1:0]  lvl,
   input  logic [LANES*MAG_W-1:0]  mag,
   input  logic [LANES-1:0]        pos,
   output logic signed [ROW_W-1:0] sum,
   output logic [LVL_W-1:0]        lvl_out
);
   localparam logic signed [ROW_W-1:0] LMAX_S = ROW_W'((1 << LVL_W) - 1);
   localparam logic signed [ROW_W-1:0] RND    = ROW_W'((1 << ROW_SHIFT) - 1);

   logic signed [ROW_W-1:0] term;
   logic signed [ROW_W-1:0] quo;

   always_comb begin
      sum  = '0;
      term = '0;
      for (int i = 0; i < LANES; i++) begin
         term = ROW_W'(lvl[i*LVL_W +: LVL_W]) * ROW_W'(mag[i*MAG_W +: MAG_W]);
         sum  = pos[i] ? sum + term : sum - term;
      end
   end

   always_comb begin
      quo = (sum + RND) >>> ROW_SHIFT;
      if (sum <= 0)
         lvl_out = '0;
      else if (quo > LMAX_S)
         lvl_out = LMAX_S[LVL_W-1:0];
      else
         lvl_out = quo[LVL_W-1:0];
   end
endmodule

// File: rtl/tfe_decay_sat.sv
module tfe_decay_sat #(
   parameter int WIDE_W = 32,
   parameter int DEC_W  = 16,
   parameter int ACC_W  = 16
) (
   input  logic signed [WIDE_W-1:0] v,
   input  logic [DEC_W-1:0]         dec,
   output logic signed [WIDE_W-1:0] v_dec,
   output logic signed [ACC_W-1:0]  v_sat
);
   localparam logic signed [WIDE_W-1:0] SMAX = WIDE_W'((64'sd1 <<< (ACC_W-1)) - 64'sd1);
   localparam logic signed [WIDE_W-1:0] SMIN = -SMAX - WIDE_W'(1);

   logic signed [WIDE_W-1:0] d;

   always_comb begin
      d     = $signed({{(WIDE_W-DEC_W){1'b0}}, dec});
      v_dec = v;
      if (dec != '0) begin
         if (v > 0)
            v_dec = (v > d) ? v - d : '0;
         else if (v < 0)
            v_dec = (v + d < 0) ? v + d : '0;
      end
   end

   always_comb begin
      if (v_dec > SMAX)
         v_sat = SMAX[ACC_W-1:0];
      else if (v_dec < SMIN)
         v_sat = SMIN[ACC_W-1:0];
      else
         v_sat = v_dec[ACC_W-1:0];
   end
endmodule

// File: rtl/tile_fuse_engine.sv
module tile_fuse_engine #(
   parameter int LANES     = 8,
   parameter int LVL_W     = 4,
   parameter int RAW_W     = 8,
   parameter int MAG_W     = 3,
   parameter int ACC_W     = 16,
   parameter int DEC_W     = 16,
   parameter int ROW_SHIFT = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      active,
   input  logic                      locked_in,
   input  logic                      bake_ok,
   input  logic [LANES*RAW_W-1:0]    lane_raw,
   input  logic [LANES*LANES*MAG_W-1:0] w_mag,
   input  logic [LANES*LANES-1:0]    w_pos,
   input  logic signed [ACC_W-1:0]   thr_lo,
   input  logic signed [ACC_W-1:0]   thr_hi,
   input  logic [DEC_W-1:0]          decay,
   input  logic signed [ACC_W-1:0]   acc_in,
   output logic signed [ACC_W-1:0]   acc_out,
   output logic                      locked_out,
   output logic                      fire,
   output logic                      done,
   output logic [LANES*LVL_W-1:0]    drive,
   output logic [LANES-1:0]          lane_clip
);
   import tfe_pkg::*;

   localparam int RC_W    = $clog2(LANES);
   localparam int ROW_W   = LVL_W + MAG_W + RC_W + 1;
   localparam int DELTA_W = ROW_W + RC_W;
   localparam int WIDE_W  = 32;
   localparam int ROW_BITS = LANES * MAG_W;

   if (LANES < 2 || RAW_W < LVL_W || WIDE_W <= ACC_W + 1 ||
       WIDE_W <= DEC_W + 1 || DELTA_W >= WIDE_W) begin : g_bad_cfg
      $error("tile_fuse_engine: unsupported parameter combination");
   end

   tfe_state_e                st;
   logic [RC_W-1:0]           row_idx;
   logic [LANES*LVL_W-1:0]    lvl_now, lvl_q;
   logic [LANES-1:0]          clip_now, clip_q;
   logic signed [ACC_W-1:0]   acc_q;
   logic signed [DELTA_W-1:0] delta_q;
   logic                      bake_q;
   logic [LVL_W-1:0]          rowo_q [LANES];
   logic                      busy;

   assign busy = (st != ST_IDLE);

   // one clamp per lane
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      tfe_lane_clamp #(.RAW_W(RAW_W), .LVL_W(LVL_W)) u_clamp (
         .raw  (lane_raw[g*RAW_W +: RAW_W]),
         .lvl  (lvl_now[g*LVL_W +: LVL_W]),
         .clip (clip_now[g])
      );
   end

   logic signed [ROW_W-1:0] row_sum;
   logic [LVL_W-1:0]        row_lvl;

   tfe_row_mac #(.LANES(LANES), .LVL_W(LVL_W), .MAG_W(MAG_W),
                 .ROW_W(ROW_W), .ROW_SHIFT(ROW_SHIFT)) u_mac (
      .lvl     (lvl_q),
      .mag     (w_mag[int'(row_idx)*ROW_BITS +: ROW_BITS]),
      .pos     (w_pos[int'(row_idx)*LANES +: LANES]),
      .sum     (row_sum),
      .lvl_out (row_lvl)
   );

   logic signed [WIDE_W-1:0] dec_src, dec_wide;
   logic signed [ACC_W-1:0]  dec_sat;

   assign dec_src = (st == ST_FIN) ? WIDE_W'(acc_q) + WIDE_W'(delta_q) : WIDE_W'(acc_in);

   tfe_decay_sat #(.WIDE_W(WIDE_W), .DEC_W(DEC_W), .ACC_W(ACC_W)) u_dec (
      .v     (dec_src),
      .dec   (decay),
      .v_dec (dec_wide),
      .v_sat (dec_sat)
   );

   logic rng_on, pre_in, post_in, will_lock;

   always_comb begin
      rng_on    = thr_lo < thr_hi;
      pre_in    = rng_on && (WIDE_W'(thr_lo) <= dec_src) && (dec_src <= WIDE_W'(thr_hi));
      post_in   = rng_on && (thr_lo <= dec_sat) && (dec_sat <= thr_hi);
      will_lock = bake_q && post_in && ((delta_q != '0) || ((decay != '0) && !pre_in));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         row_idx    <= '0;
         lvl_q      <= '0;
         clip_q     <= '0;
         acc_q      <= '0;
         delta_q    <= '0;
         bake_q     <= 1'b0;
         acc_out    <= '0;
         locked_out <= 1'b0;
         fire       <= 1'b0;
         done       <= 1'b0;
         drive      <= '0;
         lane_clip  <= '0;
         for (int i = 0; i < LANES; i++) rowo_q[i] <= '0;
      end else begin
         done <= 1'b0;
         fire <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               lvl_q  <= lvl_now;
               clip_q <= clip_now;
               acc_q  <= acc_in;
               bake_q <= bake_ok;
               if (!active) begin
                  acc_out    <= '0;
                  locked_out <= 1'b0;
                  drive      <= '0;
                  lane_clip  <= '0;
                  done       <= 1'b1;
               end else if (locked_in) begin
                  acc_out    <= dec_sat;
                  locked_out <= 1'b1;
                  drive      <= lvl_now;
                  lane_clip  <= clip_now;
                  done       <= 1'b1;
               end else begin
                  st      <= ST_ROWS;
                  row_idx <= '0;
                  delta_q <= '0;
               end
            end
            ST_ROWS: begin
               delta_q         <= delta_q + DELTA_W'(row_sum);
               rowo_q[row_idx] <= row_lvl;
               if (row_idx == RC_W'(LANES-1))
                  st <= ST_FIN;
               else
                  row_idx <= row_idx + 1'b1;
            end
            ST_FIN: begin
               acc_out    <= dec_sat;
               locked_out <= will_lock;
               fire       <= will_lock;
               lane_clip  <= clip_q;
               done       <= 1'b1;
               for (int i = 0; i < LANES; i++)
                  drive[i*LVL_W +: LVL_W] <= will_lock ? lvl_q[i*LVL_W +: LVL_W] : rowo_q[i];
               st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tile_fuse_chk.sv
module tile_fuse_chk #(
   parameter int ACC_W = 16,
   parameter int LANES = 8,
   parameter int LVL_W = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic                    busy,
   input logic                    active,
   input logic                    locked_in,
   input logic                    done,
   input logic                    fire,
   input logic                    locked_out,
   input logic signed [ACC_W-1:0] acc_out,
   input logic [LANES*LVL_W-1:0]  drive,
   input logic signed [ACC_W-1:0] thr_lo,
   input logic signed [ACC_W-1:0] thr_hi
);
   a_r7_dead_tile_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !active) |=> (done && acc_out == '0 && !locked_out && drive == '0));

   a_r6_latched_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && active && locked_in) |=> (done && locked_out && !fire));

   a_r8_fire_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (done && locked_out));

   a_r4_window_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (thr_lo < thr_hi));

   a_r5_acc_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (thr_lo <= acc_out && acc_out <= thr_hi));

   a_r9_busy_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |-> !fire);
endmodule

bind tile_fuse_engine tile_fuse_chk #(.ACC_W(ACC_W), .LANES(LANES), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/tb_tile_fuse_engine.sv
`timescale 1ns/1ps
module tb_tile_fuse_engine;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, active = 1'b0, locked_in = 1'b0, bake_ok = 1'b0;
   logic [63:0]  lane_raw = '0;
   logic [191:0] w_mag = '0;
   logic [63:0]  w_pos = '0;
   logic signed [15:0] thr_lo = '0, thr_hi = '0, acc_in = '0;
   logic [15:0] decay = '0;
   logic signed [15:0] acc_out;
   logic locked_out, fire, done;
   logic [31:0] drive;
   logic [7:0]  lane_clip;

   always #2 clk = ~clk;

   tile_fuse_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .active(active), .locked_in(locked_in),
      .bake_ok(bake_ok), .lane_raw(lane_raw), .w_mag(w_mag), .w_pos(w_pos),
      .thr_lo(thr_lo), .thr_hi(thr_hi), .decay(decay), .acc_in(acc_in),
      .acc_out(acc_out), .locked_out(locked_out), .fire(fire), .done(done),
      .drive(drive), .lane_clip(lane_clip)
   );

   int total = 0, bad = 0;
   bit finished = 0;

   int raw [8];
   int mg [8][8];
   bit ps [8][8];
   int lo, hi, dc, ain;
   bit act, lki, bk;

   int e_acc, e_lat;
   bit e_lk, e_fire;
   logic [31:0] e_drv;
   logic [7:0]  e_clip;

   task automatic check(string req, string what, longint act_v, longint exp_v);
      total++;
      if (act_v != exp_v) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act_v, exp_v);
      end
   endtask

   function automatic int dec_f(int v, int d);
      if (d > 0) begin
         if (v > 0) return (v > d) ? v - d : 0;
         if (v < 0) return (v + d < 0) ? v + d : 0;
      end
      return v;
   endfunction

   function automatic int sat_f(int v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   task automatic model();
      int lv [8];
      int ro [8];
      int delta, tmp, a, s;
      bit pre, inr;
      for (int i = 0; i < 8; i++) begin
         lv[i] = (raw[i] > 15) ? 15 : raw[i];
         e_clip[i] = raw[i] > 15;
      end
      e_fire = 0;
      if (!act) begin
         e_acc = 0; e_lk = 0; e_drv = '0; e_clip = '0; e_lat = 1;
      end else if (lki) begin
         e_acc = sat_f(dec_f(ain, dc)); e_lk = 1; e_lat = 1;
         for (int i = 0; i < 8; i++) e_drv[i*4 +: 4] = lv[i][3:0];
      end else begin
         delta = 0;
         for (int r = 0; r < 8; r++) begin
            s = 0;
            for (int i = 0; i < 8; i++) s += ps[r][i] ? lv[i]*mg[r][i] : -lv[i]*mg[r][i];
            ro[r] = (s <= 0) ? 0 : (((s + 7) / 8 > 15) ? 15 : (s + 7) / 8);
            delta += s;
         end
         tmp = ain + delta;
         pre = (lo < hi) && (lo <= tmp) && (tmp <= hi);
         a = sat_f(dec_f(tmp, dc));
         inr = (lo < hi) && (lo <= a) && (a <= hi);
         e_acc = a;
         e_lk = bk && inr && ((delta != 0) || (dc > 0 && !pre));
         e_fire = e_lk;
         e_lat = 10;
         for (int i = 0; i < 8; i++) e_drv[i*4 +: 4] = e_lk ? lv[i][3:0] : ro[i][3:0];
      end
   endtask

   task automatic drive_inputs();
      for (int i = 0; i < 8; i++) lane_raw[i*8 +: 8] = raw[i][7:0];
      for (int r = 0; r < 8; r++)
         for (int i = 0; i < 8; i++) begin
            w_mag[(r*8+i)*3 +: 3] = mg[r][i][2:0];
            w_pos[r*8+i] = ps[r][i];
         end
      thr_lo = lo[15:0]; thr_hi = hi[15:0]; decay = dc[15:0]; acc_in = ain[15:0];
      active = act; locked_in = lki; bake_ok = bk;
   endtask

   task automatic setup(int lvl, int m, bit p);
      for (int i = 0; i < 8; i++) raw[i] = lvl;
      for (int r = 0; r < 8; r++)
         for (int i = 0; i < 8; i++) begin mg[r][i] = m; ps[r][i] = p; end
      lo = 0; hi = 0; dc = 0; ain = 0; act = 1; lki = 0; bk = 1;
   endtask

   task automatic run_case(string req, bit poke);
      int cyc;
      model();
      @(negedge clk);
      drive_inputs();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 40) begin
         if (poke && cyc == 3) begin start = 1'b1; active = 1'b0; acc_in = 16'sd1234; end
         @(negedge clk);
         if (poke && cyc == 3) begin start = 1'b0; active = act; acc_in = ain[15:0]; end
         cyc++;
      end
      check(req, "R9 latency", cyc, e_lat);
      check(req, "R3 acc_out", int'(acc_out), e_acc);
      check(req, "R5 locked_out", locked_out, e_lk);
      check(req, "R8 fire", fire, e_fire);
      check(req, "R2 drive", drive, e_drv);
      check(req, "R1 lane_clip", lane_clip, e_clip);
      @(negedge clk);
      check(req, "R9 done one cycle", done, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R11", "done", done, 0);
      check("R11", "acc_out", int'(acc_out), 0);
      check("R11", "locked_out", locked_out, 0);
      check("R11", "drive", drive, 0);
      check("R11", "lane_clip", lane_clip, 0);
      rst_n = 1'b1;
      @(negedge clk);

      setup(3, 2, 1); act = 0; ain = 500; run_case("R7", 0);
      setup(20, 5, 1); lki = 1; ain = 100; dc = 30; run_case("R6", 0);
      setup(4, 5, 1); lki = 1; ain = -10; dc = 30; run_case("R6", 0);
      setup(1, 1, 1); lo = 10; hi = 100; run_case("R5", 0);
      setup(2, 3, 1); lo = 384; hi = 384; run_case("R4", 0);
      setup(2, 3, 1); lo = 500; hi = 100; ain = 200; run_case("R4", 0);
      setup(5, 0, 1); ain = 150; dc = 60; hi = 100; run_case("R5", 0);
      setup(5, 0, 1); ain = 50; hi = 100; run_case("R5", 0);
      setup(1, 1, 1); lo = 10; hi = 100; bk = 0; run_case("R5", 0);
      setup(15, 7, 1); ain = 32767; run_case("R3", 0);
      setup(15, 7, 0); ain = -32768; run_case("R3", 0);
      setup(1, 1, 1); dc = 1000; lo = -5; hi = 5; run_case("R3", 0);
      setup(1, 1, 1); ain = -100; dc = 20; run_case("R3", 0);
      setup(1, 1, 1); lo = 10; hi = 100; run_case("R10", 1);
      setup(0, 3, 1);
      for (int i = 0; i < 8; i++) raw[i] = i * 30;
      for (int r = 0; r < 8; r++) ps[r][r] = 0;
      run_case("R1", 0);

      for (int n = 0; n < 300; n++) begin
         int a, b;
         for (int i = 0; i < 8; i++) raw[i] = ($urandom_range(0, 3) == 0) ? $urandom_range(16, 255) : $urandom_range(0, 15);
         for (int r = 0; r < 8; r++)
            for (int i = 0; i < 8; i++) begin mg[r][i] = $urandom_range(0, 7); ps[r][i] = $urandom_range(0, 1); end
         a = int'($urandom_range(0, 16000)) - 8000;
         b = int'($urandom_range(0, 16000)) - 8000;
         lo = (a < b) ? a : b; hi = (a < b) ? b : a;
         dc = ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(0, 2000);
         ain = int'($urandom_range(0, 65535)) - 32768;
         act = $urandom_range(0, 9) != 0;
         lki = $urandom_range(0, 4) == 0;
         bk = $urandom_range(0, 9) != 0;
         run_case("R2", 0);
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog R9: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule